// File: doc/BRIEF.md
# Six-Pin Bidirectional GPIO Port

This block is a general-purpose I/O port of six pins, reached over a small 8-bit register bus. It holds two registers. The output latch holds the value each pin drives. The direction register decides, pin by pin, whether the pad's output driver is on. Software preloads the latch and then turns pins into outputs. When it reads the port back, it sees the latch for each output pin and the synchronized pad level for each input pin.

The two lowest pins can be lent to a serial communications module. While the serial enable is high, pin 0 carries the serial transmit line and pin 1 feeds the serial receive line. The stored direction bits are kept, and they apply again as soon as the enable drops. Pad inputs pass through a two-flop synchronizer before anything inside the block uses them.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the latch, the direction register and both synchronizer stages hold zero. So `pin_oe` and `pin_out` are 0, and reads at both addresses return 0 while the pads stay low.
- R2: The latch sits at bus address 0x08 and the direction register at 0x0C. A write (`bus_wr` high) loads `bus_wdata[5:0]` into the addressed register on the rising clock edge. A write to any other address changes neither register.
- R3: Register bits 7 and 6 do not exist. Writes to them have no effect, and reads return 0 in those positions at both addresses.
- R4: Outside the serial override, `pin_oe[i]` equals direction bit i and `pin_out[i]` equals latch bit i, where 1 means output.
- R5: A read of 0x08 returns, for each bit i, the latch bit if direction bit i is 1, and otherwise the synchronized level of `pin_in[i]`. A read of 0x0C returns the stored direction bits.
- R6: A change on `pin_in` appears in read data and on `sci_rxd` only after two rising clock edges.
- R7: The latch accepts writes whatever the direction bits hold. A value preloaded while a pin is an input is already on `pin_out` in the cycle its `pin_oe` rises.
- R8: While `sci_en` is 1, `pin_oe[0]` is 1 and `pin_out[0]` follows `sci_txd`. `pin_oe[1]` is 0, and `sci_rxd` carries the synchronized `pin_in[1]`. The stored direction bits stay unchanged, and a read of 0x0C still returns them.
- R9: While `sci_en` is 0, `sci_rxd` is held at 1 (line idle), and pins 0 and 1 follow their own direction and latch bits again.
- R10: `bus_rdata` is 0 whenever `bus_rd` is low or the address matches neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 8 | Read data |
| pin_out | output | 6 | Per-pin output value to the pad |
| pin_oe | output | 6 | Per-pin output driver enable |
| pin_in | input | 6 | Per-pin pad level, asynchronous |
| sci_en | input | 1 | Serial module enable; takes over pins 0 and 1 |
| sci_txd | input | 1 | Serial transmit data to drive on pin 0 |
| sci_rxd | output | 1 | Serial receive data taken from pin 1 |

## Verification
The bench goes after the read-back mix. With direction bits set differently from the pad levels, a design that always returned the latch, or always returned the pad, reports wrong bits on input pins or on output pins. It counts the synchronizer delay exactly, so a design with one stage or three shows a new pad level one cycle early or one cycle late. It moves the serial enable while the direction bits point the other way. A design that wrote the override into the stored direction would read back the forced values, and one that ignored the override would leave pin 0 undriven or drive pin 1. Further cases are writes with bits 7:6 set, writes to unmapped addresses, and a latch preload before a pin becomes an output. These catch a design that stores phantom bits, decodes the address loosely, or gates latch writes by direction.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    parameter int unsigned PORT_PINS   = 6;
    parameter int unsigned BUS_DW      = 8;
    parameter int unsigned BUS_AW      = 8;
    parameter int unsigned SYNC_DEPTH  = 2;
    parameter int unsigned SER_TX_PIN  = 0;
    parameter int unsigned SER_RX_PIN  = 1;
    parameter logic [7:0]  LATCH_ADDR  = 8'h08;
    parameter logic [7:0]  DIRECT_ADDR = 8'h0C;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int unsigned PINS = 6,
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] LATCH_ADDR = 8'h08,
    parameter logic [AW-1:0] DIRECT_ADDR = 8'h0C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            wr,
    output logic [PINS-1:0] latch_q,
    output logic [PINS-1:0] dir_q
);
    import gpio_port_pkg::*;

    reg_sel_e        sel;
    logic [PINS-1:0] wbits;
    logic            unused_wdata_hi;

    assign wbits           = wdata[PINS-1:0];
    assign unused_wdata_hi = ^wdata[DW-1:PINS];

    always_comb begin
        if (addr == LATCH_ADDR)       sel = SEL_LATCH;
        else if (addr == DIRECT_ADDR) sel = SEL_DIR;
        else                          sel = SEL_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_LATCH: latch_q <= wbits;
                SEL_DIR:   dir_q   <= wbits;
                default:   ;
            endcase
        end
    end

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == LATCH_ADDR) |=> latch_q == $past(wdata[PINS-1:0]));

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == DIRECT_ADDR) |=> $stable(dir_q));

    // R7
    latch_any_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == LATCH_ADDR) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int unsigned PINS = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_sync
);
    logic [PINS-1:0] stage_q [STAGES];
    logic            up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign pin_sync = stage_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    // R6
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> stage_q[0] == $past(pin_in));
endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
    parameter int unsigned PINS = 6,
    parameter int unsigned TX_PIN = 0,
    parameter int unsigned RX_PIN = 1
) (
    input  logic [PINS-1:0] latch_q,
    input  logic [PINS-1:0] dir_q,
    input  logic            rx_sync,
    input  logic            sci_en,
    input  logic            sci_txd,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            sci_rxd
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        if (i == TX_PIN) begin : g_tx
            assign pin_oe[i]  = sci_en | dir_q[i];
            assign pin_out[i] = sci_en ? sci_txd : latch_q[i];
        end else if (i == RX_PIN) begin : g_rx
            assign pin_oe[i]  = ~sci_en & dir_q[i];
            assign pin_out[i] = latch_q[i];
        end else begin : g_plain
            assign pin_oe[i]  = dir_q[i];
            assign pin_out[i] = latch_q[i];
        end
    end

    assign sci_rxd = sci_en ? rx_sync : 1'b1;
endmodule

// File: rtl/gpio_port_readmux.sv
module gpio_port_readmux #(
    parameter int unsigned PINS = 6,
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] LATCH_ADDR = 8'h08,
    parameter logic [AW-1:0] DIRECT_ADDR = 8'h0C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            rd,
    input  logic [PINS-1:0] latch_q,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] pin_sync,
    output logic [DW-1:0]   rdata
);
    localparam int unsigned PAD = DW - PINS;

    logic [PINS-1:0] port_view;

    for (genvar i = 0; i < PINS; i++) begin : g_bit
        assign port_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == LATCH_ADDR)       rdata = {{PAD{1'b0}}, port_view};
            else if (addr == DIRECT_ADDR) rdata = {{PAD{1'b0}}, dir_q};
        end
    end

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:PINS] == '0);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rdata == '0);

    // R5
    dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == DIRECT_ADDR) |-> rdata[PINS-1:0] == dir_q);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS = PORT_PINS,
    parameter int unsigned DW = BUS_DW,
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned STAGES = SYNC_DEPTH,
    parameter int unsigned TX_PIN = SER_TX_PIN,
    parameter int unsigned RX_PIN = SER_RX_PIN,
    parameter logic [AW-1:0] DATA_REG_ADDR = LATCH_ADDR,
    parameter logic [AW-1:0] DIR_REG_ADDR = DIRECT_ADDR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    input  logic [PINS-1:0] pin_in,
    input  logic            sci_en,
    input  logic            sci_txd,
    output logic            sci_rxd
);
    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] pin_sync;

    gpio_port_regs #(
        .PINS(PINS), .DW(DW), .AW(AW),
        .LATCH_ADDR(DATA_REG_ADDR), .DIRECT_ADDR(DIR_REG_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .wr(bus_wr), .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_port_sync #(.PINS(PINS), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    gpio_port_pinmux #(.PINS(PINS), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)) u_pinmux (
        .latch_q(latch_q), .dir_q(dir_q), .rx_sync(pin_sync[RX_PIN]),
        .sci_en(sci_en), .sci_txd(sci_txd),
        .pin_out(pin_out), .pin_oe(pin_oe), .sci_rxd(sci_rxd)
    );

    gpio_port_readmux #(
        .PINS(PINS), .DW(DW), .AW(AW),
        .LATCH_ADDR(DATA_REG_ADDR), .DIRECT_ADDR(DIR_REG_ADDR)
    ) u_readmux (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd),
        .latch_q(latch_q), .dir_q(dir_q), .pin_sync(pin_sync),
        .rdata(bus_rdata)
    );

    // R8
    tx_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_en |-> (pin_oe[TX_PIN] && pin_out[TX_PIN] == sci_txd));

    // R8
    rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_en |-> !pin_oe[RX_PIN]);

    // R9
    rxd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sci_en |-> sci_rxd);

    // R4
    plain_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sci_en |-> pin_oe == dir_q);
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic       clk;
    logic       rst_n;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_rdata;
    logic [5:0] pin_out;
    logic [5:0] pin_oe;
    logic [5:0] pin_in;
    logic       sci_en;
    logic       sci_txd;
    logic       sci_rxd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [5:0] latch_m;
    logic [5:0] dir_m;
    logic [5:0] s1_m;
    logic [5:0] s2_m;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in),
        .sci_en(sci_en), .sci_txd(sci_txd), .sci_rxd(sci_rxd)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [7:0] exp_rdata(logic [7:0] a, logic r);
        if (!r) return 8'h00;
        if (a == 8'h08) return {2'b00, (dir_m & latch_m) | (~dir_m & s2_m)};
        if (a == 8'h0C) return {2'b00, dir_m};
        return 8'h00;
    endfunction

    function automatic logic [5:0] exp_oe(logic se);
        logic [5:0] v;
        v = dir_m;
        if (se) begin
            v[0] = 1'b1;
            v[1] = 1'b0;
        end
        return v;
    endfunction

    function automatic logic [5:0] exp_out(logic se, logic tx);
        logic [5:0] v;
        v = latch_m;
        if (se) v[0] = tx;
        return v;
    endfunction

    function automatic logic exp_rxd(logic se);
        return se ? s2_m[1] : 1'b1;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic [7:0] a, input logic [7:0] wd, input logic w,
                        input logic r, input logic [5:0] p, input logic se,
                        input logic tx, input string tag);
        string trd;
        string tpin;
        string trx;
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_wr = w; bus_rd = r;
        pin_in = p; sci_en = se; sci_txd = tx;
        #1;
        if (tag != "") begin
            trd = tag; tpin = tag; trx = tag;
        end else begin
            trd  = (!r || (a != 8'h08 && a != 8'h0C)) ? "R10" :
                   (a == 8'h08) ? "R5" : "R2";
            tpin = se ? "R8" : "R4";
            trx  = se ? "R8" : "R9";
        end
        chk(trd, "bus_rdata", bus_rdata, exp_rdata(a, r));
        chk(tpin, "pin_oe", {2'b00, pin_oe}, {2'b00, exp_oe(se)});
        chk(tpin, "pin_out", {2'b00, pin_out}, {2'b00, exp_out(se, tx)});
        chk(trx, "sci_rxd", {7'd0, sci_rxd}, {7'd0, exp_rxd(se)});
        @(posedge clk);
        if (w && a == 8'h08) latch_m = wd[5:0];
        if (w && a == 8'h0C) dir_m = wd[5:0];
        s2_m = s1_m;
        s1_m = p;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [5:0] pins;
        logic       se;
        process::self().srandom(32'h5EED_0C08);
        rst_n = 1'b0;
        bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
        pin_in = 6'h00; sci_en = 1'b0; sci_txd = 1'b0;
        latch_m = '0; dir_m = '0; s1_m = '0; s2_m = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "pin_oe in reset", {2'b00, pin_oe}, 8'h00);
        chk("R1", "pin_out in reset", {2'b00, pin_out}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reads after reset
        step(8'h08, 8'h00, 0, 1, 6'h00, 0, 0, "R1");
        step(8'h0C, 8'h00, 0, 1, 6'h00, 0, 0, "R1");

        // R3: upper bits ignored
        step(8'h0C, 8'hFF, 1, 0, 6'h00, 0, 0, "R3");
        step(8'h0C, 8'h00, 0, 1, 6'h00, 0, 0, "R3");
        step(8'h08, 8'hC0, 1, 0, 6'h00, 0, 0, "R3");
        step(8'h08, 8'h00, 0, 1, 6'h00, 0, 0, "R3");

        // R2: unmapped address write changes nothing
        step(8'h04, 8'h15, 1, 0, 6'h00, 0, 0, "R2");
        step(8'h09, 8'h2A, 1, 0, 6'h00, 0, 0, "R2");
        step(8'h0C, 8'h00, 0, 1, 6'h00, 0, 0, "R2");
        step(8'h08, 8'h00, 0, 1, 6'h00, 0, 0, "R2");

        // R7: preload with pins as inputs, then switch to output
        step(8'h0C, 8'h00, 1, 0, 6'h00, 0, 0, "R7");
        step(8'h08, 8'h2A, 1, 0, 6'h00, 0, 0, "R7");
        step(8'h0C, 8'h3F, 1, 0, 6'h00, 0, 0, "R7");
        step(8'h08, 8'h00, 0, 1, 6'h00, 0, 0, "R7");

        // R6: pad change seen after exactly two edges
        step(8'h0C, 8'h00, 1, 0, 6'h00, 0, 0, "R6");
        step(8'h08, 8'h00, 0, 1, 6'h15, 0, 0, "R6");
        step(8'h08, 8'h00, 0, 1, 6'h15, 0, 0, "R6");
        step(8'h08, 8'h00, 0, 1, 6'h15, 0, 0, "R6");
        step(8'h08, 8'h00, 0, 1, 6'h15, 0, 0, "R6");

        // R5: mixed direction
        step(8'h0C, 8'h0F, 1, 0, 6'h15, 0, 0, "R5");
        step(8'h08, 8'h33, 1, 1, 6'h15, 0, 0, "R5");
        step(8'h08, 8'h00, 0, 1, 6'h2A, 0, 0, "R5");
        step(8'h08, 8'h00, 0, 1, 6'h2A, 0, 0, "R5");
        step(8'h08, 8'h00, 0, 1, 6'h2A, 0, 0, "R5");

        // R8: serial override against opposite direction bits
        step(8'h0C, 8'h02, 1, 0, 6'h02, 1, 1, "R8");
        step(8'h0C, 8'h00, 0, 1, 6'h02, 1, 0, "R8");
        step(8'h0C, 8'h00, 0, 1, 6'h00, 1, 1, "R8");
        step(8'h0C, 8'h00, 0, 1, 6'h00, 1, 0, "R8");
        step(8'h08, 8'h00, 0, 1, 6'h00, 1, 1, "R8");

        // R9: release
        step(8'h0C, 8'h00, 0, 1, 6'h02, 0, 1, "R9");
        step(8'h08, 8'h00, 0, 1, 6'h02, 0, 0, "R9");

        // R10: no read strobe, unmapped read
        step(8'h0C, 8'h00, 0, 0, 6'h3F, 0, 0, "R10");
        step(8'h0D, 8'h00, 0, 1, 6'h3F, 0, 0, "R10");

        // Random traffic, R4 R5 R8 R9 R10 by default tags
        pins = 6'h00;
        se = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            int unsigned pick;
            pick = $urandom_range(0, 9);
            a = (pick < 4) ? 8'h08 : (pick < 8) ? 8'h0C : 8'($urandom);
            if ($urandom_range(0, 3) == 0) pins = 6'($urandom);
            if ($urandom_range(0, 19) == 0) se = ~se;
            step(a, 8'($urandom), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 9) < 7), pins, se,
                 1'($urandom_range(0, 1)), "");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule